// File: doc/BRIEF.md
# Memory-Mapped SPI Master

This block is a SPI master that a processor drives through a small 32-bit register bus. Software picks the clock divider and the clock polarity, phase and bit order, flushes the two 8-bit-wide FIFOs, and loads how many words to send and how many to receive. It fills the transmit FIFO and then sets a go bit. The shift engine then moves exactly the loaded number of 8-bit words over SCK and MOSI and samples MISO.

Each received word goes into the receive FIFO, and software pops it from a data register. The engine waits with SCK at its idle level whenever it has nothing left to send or nowhere to store a received word. It also waits when go is cleared. Two completion flags report when the remaining transmit count or the remaining receive count reaches zero. Chip select is a plain register bit that software drives.

Top module: `spim_core`

## Requirements
- R1: After reset, cs_n is 1 and sck is 0. The divider reads 2, both counts read 0, the completion register reads 3 and the FIFO status register reads 0x0A (both FIFOs empty).
- R2: The register map uses byte offsets: 0x00 control, 0x04 mode, 0x08 completion, 0x0C select, 0x10 transmit push (write), 0x14 receive pop (read), 0x18 divider, 0x1C transmit count, 0x20 receive count, 0x24 FIFO status. Words come out of the receive FIFO in the order they went into the transmit FIFO.
- R3: The transmit FIFO holds FIFO_DEPTH words and ignores a push while it is full. The FIFO status fields are: bit 0 transmit full, bit 1 transmit empty, bit 2 receive full, bit 3 receive empty, bits 15:8 transmit level, bits 23:16 receive level.
- R4: A pop from the empty receive FIFO returns 0 and leaves the FIFO state unchanged.
- R5: A divider write is clamped to the range 2 to 2**DIV_W-1, and the clamped value is what reads back.
- R6: Within a word, successive SCK transitions are exactly divider-value clock cycles apart.
- R7: Mode bit 1 (CPOL) sets the idle SCK level. With mode bit 0 (CPHA) at 0, MOSI is valid at the leading edge. With CPHA at 1, MOSI is valid at the trailing edge.
- R8: With mode bit 2 at 0 the data goes most significant bit first. With mode bit 2 at 1 it goes least significant bit first. The same order applies to MISO.
- R9: One run moves exactly max(transmit count, receive count) words, with 16 SCK transitions per word. Once the transmit count is used up, the engine sends zero words. Once the receive count is used up, it drops received words. Completion bit 0 is set when the remaining transmit count is 0, and bit 1 is set when the remaining receive count is 0.
- R10: The engine stalls with SCK idle while transmit words remain and the transmit FIFO is empty, or while receive words remain and the receive FIFO is full. It resumes once the condition clears.
- R11: Writing 1 to control bit 1 empties the transmit FIFO, and writing 1 to control bit 2 empties the receive FIFO.
- R12: cs_n equals bit 0 of the select register.
- R13: Control bit 0 is the go bit. Clearing it stops shifting at once: SCK goes to idle and the remaining counts are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: a FIFO depth of 16, 16-bit counts and an 11-bit divider. With a 16-entry FIFO, the seventeenth push is rejected and a receive count of 18 fills the receive FIFO part way through a run. Both pointers also wrap. An 11-bit divider lets a write of zero and an oversized write test both clamp limits. MISO is looped back to MOSI, and a bus-side monitor samples MOSI on the sampling edge that CPOL and CPHA imply, so each of the eight mode and bit-order combinations is checked against an independently computed bit sequence.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 8;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_DONE  = 8'h08;
  localparam logic [7:0] OFS_SEL   = 8'h0C;
  localparam logic [7:0] OFS_TXD   = 8'h10;
  localparam logic [7:0] OFS_RXD   = 8'h14;
  localparam logic [7:0] OFS_DIV   = 8'h18;
  localparam logic [7:0] OFS_TXCNT = 8'h1C;
  localparam logic [7:0] OFS_RXCNT = 8'h20;
  localparam logic [7:0] OFS_FSTAT = 8'h24;

  typedef struct packed {
    logic lsb_first;
    logic cpol;
    logic cpha;
  } spim_mode_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 data_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [LW-1:0] lvl_q, lvl_n;
  logic          push_ok, pop_ok;

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem[rp_q];
  assign level_o = lvl_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    lvl_n = lvl_q;
    if (flush_i) begin
      wp_n  = '0;
      rp_n  = '0;
      lvl_n = '0;
    end else begin
      if (push_ok) wp_n = bump(wp_q);
      if (pop_ok)  rp_n = bump(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   lvl_n = lvl_q + LW'(1);
        2'b01:   lvl_n = lvl_q - LW'(1);
        default: lvl_n = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      lvl_q <= lvl_n;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i && !flush_i) |=> (level_o == $past(level_o)));
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i && !flush_i) |=> (level_o == '0));
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LW'(DEPTH));
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty_o);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DIV_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tx_need_i,
  input  logic              rx_need_i,
  input  logic              tx_avail_i,
  input  logic              rx_room_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  spim_mode_t        mode_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              tx_pop_o,
  output logic              word_done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int EDGE_W = $clog2(2*WORD_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2*WORD_W-1);

  logic              busy_q, busy_n;
  logic [DIV_W-1:0]  hcnt_q, hcnt_n;
  logic [EDGE_W-1:0] edge_q, edge_n;
  logic              sck_q, sck_n;
  logic [WORD_W-1:0] txsh_q, txsh_n, rxsh_q, rxsh_n;
  logic              start, tick, sample, shift;
  logic [WORD_W-1:0] rx_shifted;

  assign start  = run_i && !busy_q && (tx_need_i || rx_need_i)
                  && (!tx_need_i || tx_avail_i) && (!rx_need_i || rx_room_i);
  assign tick   = busy_q && (hcnt_q == '0);
  assign sample = tick && (edge_q[0] == mode_i.cpha);
  assign shift  = tick && (edge_q[0] != mode_i.cpha)
                  && (edge_q != '0) && (edge_q != LAST_EDGE);
  assign rx_shifted = mode_i.lsb_first ? {miso_i, rxsh_q[WORD_W-1:1]}
                                       : {rxsh_q[WORD_W-2:0], miso_i};

  assign tx_pop_o    = start && tx_need_i;
  assign word_done_o = run_i && tick && (edge_q == LAST_EDGE);
  assign rx_word_o   = sample ? rx_shifted : rxsh_q;
  assign sck_o       = sck_q ^ mode_i.cpol;
  assign mosi_o      = mode_i.lsb_first ? txsh_q[0] : txsh_q[WORD_W-1];

  always_comb begin
    busy_n = busy_q;
    hcnt_n = hcnt_q;
    edge_n = edge_q;
    sck_n  = sck_q;
    txsh_n = txsh_q;
    rxsh_n = rxsh_q;
    if (!run_i) begin
      busy_n = 1'b0;
      sck_n  = 1'b0;
    end else if (start) begin
      busy_n = 1'b1;
      hcnt_n = div_i - DIV_W'(1);
      edge_n = '0;
      sck_n  = 1'b0;
      txsh_n = tx_need_i ? tx_word_i : '0;
      rxsh_n = '0;
    end else if (busy_q) begin
      if (!tick) begin
        hcnt_n = hcnt_q - DIV_W'(1);
      end else begin
        sck_n  = ~sck_q;
        hcnt_n = div_i - DIV_W'(1);
        edge_n = edge_q + EDGE_W'(1);
        if (sample) rxsh_n = rx_shifted;
        if (shift)
          txsh_n = mode_i.lsb_first ? {1'b0, txsh_q[WORD_W-1:1]}
                                    : {txsh_q[WORD_W-2:0], 1'b0};
        if (edge_q == LAST_EDGE) busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hcnt_q <= '0;
      edge_q <= '0;
      sck_q  <= 1'b0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else begin
      busy_q <= busy_n;
      hcnt_q <= hcnt_n;
      edge_q <= edge_n;
      sck_q  <= sck_n;
      txsh_q <= txsh_n;
      rxsh_q <= rxsh_n;
    end
  end

  a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && hcnt_q != '0 && run_i) |=> $stable(sck_q));
  a_r13_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!busy_q && !sck_q));
endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso
);
  localparam int LVL_W   = $clog2(FIFO_DEPTH+1);
  localparam int DIV_MIN = 2;
  localparam int DIV_MAX = (1 << DIV_W) - 1;

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic wr_en, rd_en;
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  logic             go_q, go_n, cs_q, cs_n_nx;
  spim_mode_t       mode_q, mode_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [CNT_W-1:0] txcnt_q, txcnt_n, rxcnt_q, rxcnt_n;

  logic              tx_flush, rx_flush, tx_push, rx_pop;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic              tx_pop, word_done, tx_need, rx_need;

  assign tx_need  = (txcnt_q != '0);
  assign rx_need  = (rxcnt_q != '0);
  assign tx_flush = wr_en && (bus_addr == OFS_CTRL) && bus_wdata[1];
  assign rx_flush = wr_en && (bus_addr == OFS_CTRL) && bus_wdata[2];
  assign tx_push  = wr_en && (bus_addr == OFS_TXD);
  assign rx_pop   = rd_en && (bus_addr == OFS_RXD);

  function automatic logic [DIV_W-1:0] clamp_div(input logic [31:0] v);
    if (v < 32'(DIV_MIN))      return DIV_W'(DIV_MIN);
    else if (v > 32'(DIV_MAX)) return DIV_W'(DIV_MAX);
    else                       return v[DIV_W-1:0];
  endfunction

  always_comb begin
    go_n    = go_q;
    cs_n_nx = cs_q;
    mode_n  = mode_q;
    div_n   = div_q;
    txcnt_n = txcnt_q;
    rxcnt_n = rxcnt_q;
    if (word_done && tx_need) txcnt_n = txcnt_q - CNT_W'(1);
    if (word_done && rx_need) rxcnt_n = rxcnt_q - CNT_W'(1);
    if (wr_en) begin
      case (bus_addr)
        OFS_CTRL:  go_n    = bus_wdata[0];
        OFS_MODE:  mode_n  = bus_wdata[2:0];
        OFS_SEL:   cs_n_nx = bus_wdata[0];
        OFS_DIV:   div_n   = clamp_div(bus_wdata);
        OFS_TXCNT: txcnt_n = bus_wdata[CNT_W-1:0];
        OFS_RXCNT: rxcnt_n = bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      go_q    <= 1'b0;
      cs_q    <= 1'b1;
      mode_q  <= '0;
      div_q   <= DIV_W'(DIV_MIN);
      txcnt_q <= '0;
      rxcnt_q <= '0;
    end else begin
      go_q    <= go_n;
      cs_q    <= cs_n_nx;
      mode_q  <= mode_n;
      div_q   <= div_n;
      txcnt_q <= txcnt_n;
      rxcnt_q <= rxcnt_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        OFS_CTRL:  bus_rdata[0]   = go_q;
        OFS_MODE:  bus_rdata[2:0] = mode_q;
        OFS_DONE:  bus_rdata[1:0] = {!rx_need, !tx_need};
        OFS_SEL:   bus_rdata[0]   = cs_q;
        OFS_RXD:   bus_rdata[WORD_W-1:0] = rx_empty ? '0 : rx_head;
        OFS_DIV:   bus_rdata[DIV_W-1:0]  = div_q;
        OFS_TXCNT: bus_rdata[CNT_W-1:0]  = txcnt_q;
        OFS_RXCNT: bus_rdata[CNT_W-1:0]  = rxcnt_q;
        OFS_FSTAT: begin
          bus_rdata[3:0]          = {rx_empty, rx_full, tx_empty, tx_full};
          bus_rdata[8 +: LVL_W]   = tx_lvl;
          bus_rdata[16 +: LVL_W]  = rx_lvl;
        end
        default: ;
      endcase
    end
  end

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s), .flush_i(tx_flush), .push_i(tx_push),
    .data_i(bus_wdata[WORD_W-1:0]), .pop_i(tx_pop), .data_o(tx_head),
    .level_o(tx_lvl), .full_o(tx_full), .empty_o(tx_empty));

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_s), .flush_i(rx_flush), .push_i(word_done && rx_need),
    .data_i(rx_word), .pop_i(rx_pop), .data_o(rx_head),
    .level_o(rx_lvl), .full_o(rx_full), .empty_o(rx_empty));

  spim_shifter #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_s), .run_i(go_q), .tx_need_i(tx_need),
    .rx_need_i(rx_need), .tx_avail_i(!tx_empty), .rx_room_i(!rx_full),
    .tx_word_i(tx_head), .mode_i(mode_q), .div_i(div_q), .miso_i(miso),
    .tx_pop_o(tx_pop), .word_done_o(word_done), .rx_word_o(rx_word),
    .sck_o(sck), .mosi_o(mosi));

  assign cs_n = cs_q;

  a_r5_div_range: assert property (@(posedge clk) disable iff (!rst_s)
    div_q >= DIV_W'(DIV_MIN));
  a_r10_push_has_room: assert property (@(posedge clk) disable iff (!rst_s)
    (word_done && rx_need) |-> !rx_full);
  a_r9_pop_has_word: assert property (@(posedge clk) disable iff (!rst_s)
    tx_pop |-> (!tx_empty && tx_need));
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_s)
    (word_done && tx_need && !(wr_en && bus_addr == OFS_TXCNT))
      |=> (txcnt_q == $past(txcnt_q) - CNT_W'(1)));
endmodule

// File: tb/sim_spim_core.sv
module sim_spim_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, cs_n;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  spim_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(mosi));

  // Monitor: sampling-edge capture of MOSI and spacing of SCK transitions.
  logic       tb_cpha = 1'b0, tb_cpol = 1'b0;
  logic       prev_sck = 1'b0;
  logic [7:0] mon = '0;
  int         cyc = 0, last_t = 0, toggles = 0;
  int         ivl [32];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    prev_sck <= sck;
    if (sck != prev_sck) begin
      toggles <= toggles + 1;
      ivl[(toggles + 1) % 32] <= cyc - last_t;
      last_t <= cyc;
      if ((sck != tb_cpol) == !tb_cpha) mon <= {mon[6:0], mosi};
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] d;
    d = '0;
    for (int k = 0; k < 4000; k++) begin
      br(8'h08, d);
      if (d[1:0] == 2'b11) break;
    end
    chk(req, "completion reached", d, 32'h3);
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // {mode[2:0] = lsb,cpol,cpha ; divider[11:0] ; byte[7:0]}
  localparam logic [22:0] VEC [8] = '{
    {3'd0, 12'd2, 8'hA5}, {3'd1, 12'd3, 8'h3C}, {3'd2, 12'd2, 8'h81},
    {3'd3, 12'd4, 8'h5E}, {3'd4, 12'd2, 8'h1F}, {3'd5, 12'd3, 8'hC2},
    {3'd6, 12'd5, 8'h07}, {3'd7, 12'd2, 8'hE8}};

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "cs_n", {31'b0, cs_n}, 32'h1);
    chk("R1", "sck", {31'b0, sck}, 32'h0);
    br(8'h24, d); chk("R1", "fifo status", d, 32'h0A);
    br(8'h18, d); chk("R1", "divider", d, 32'h2);
    br(8'h08, d); chk("R1", "completion", d, 32'h3);
    br(8'h1C, d); chk("R1", "tx count", d, 32'h0);

    // R12 chip select
    bw(8'h0C, 32'h0); #1 chk("R12", "cs low", {31'b0, cs_n}, 32'h0);
    bw(8'h0C, 32'h1); #1 chk("R12", "cs high", {31'b0, cs_n}, 32'h1);

    // R5 divider clamp
    bw(8'h18, 32'h0);     br(8'h18, d); chk("R5", "clamp low", d, 32'h2);
    bw(8'h18, 32'h12345); br(8'h18, d); chk("R5", "clamp high", d, 32'h7FF);

    // Vector table: modes, bit orders, dividers (R6 R7 R8 R9 R2)
    foreach (VEC[i]) begin
      logic [7:0] b;
      logic [2:0] m;
      int dv;
      m = VEC[i][22:20]; dv = int'(VEC[i][19:8]); b = VEC[i][7:0];
      bw(8'h04, {29'b0, m});
      tb_cpha = m[0]; tb_cpol = m[1];
      bw(8'h18, dv);
      bw(8'h00, 32'h6);
      bw(8'h1C, 32'h1);
      bw(8'h20, 32'h1);
      bw(8'h10, {24'b0, b});
      base = toggles;
      bw(8'h00, 32'h1);
      wait_done("R9");
      bw(8'h00, 32'h0);
      chk("R9", "sck transitions per word", toggles - base, 16);
      chk(m[2] ? "R8" : "R7", "mosi bits at sampling edge", {24'b0, mon},
          {24'b0, m[2] ? rev8(b) : b});
      for (int k = 2; k <= 16; k++)
        chk("R6", "sck half period", ivl[(base + k) % 32], dv);
      br(8'h14, d); chk("R2", "looped-back word", d, {24'b0, b});
    end

    // R3 full FIFO, R2 ordering, R4 empty pop
    bw(8'h04, 32'h0); tb_cpha = 1'b0; tb_cpol = 1'b0;
    bw(8'h18, 32'h2);
    bw(8'h00, 32'h6);
    for (int k = 0; k < 17; k++) bw(8'h10, k);
    br(8'h24, d); chk("R3", "full with level 16", d, 32'h1009);
    bw(8'h1C, 32'd16); bw(8'h20, 32'd16);
    bw(8'h00, 32'h1);
    wait_done("R9");
    bw(8'h00, 32'h0);
    br(8'h24, d); chk("R3", "rx full level 16", d, 32'h0010_0006);
    for (int k = 0; k < 16; k++) begin
      br(8'h14, d); chk("R2", "fifo order", d, k);
    end
    br(8'h14, d); chk("R4", "empty pop returns 0", d, 32'h0);
    br(8'h24, d); chk("R4", "empty pop leaves state", d, 32'h0A);

    // R10 receive-full stall, R9 zeros sent after tx count ends
    bw(8'h1C, 32'd0); bw(8'h20, 32'd18);
    bw(8'h00, 32'h1);
    repeat (800) @(negedge clk);
    br(8'h24, d); chk("R10", "rx stalled full", d[23:16], 32'd16);
    br(8'h20, d); chk("R10", "rx words left", d, 32'd2);
    br(8'h08, d); chk("R9", "only tx done", d, 32'h1);
    chk("R10", "sck idle while stalled", {31'b0, sck}, 32'h0);
    br(8'h14, d); chk("R9", "zero word sent", d, 32'h0);
    br(8'h14, d);
    wait_done("R10");
    br(8'h24, d); chk("R9", "exactly 18 words", d[23:16], 32'd16);
    bw(8'h00, 32'h4);

    // R10 transmit-empty stall
    bw(8'h00, 32'h0);
    bw(8'h1C, 32'd2); bw(8'h20, 32'd0);
    bw(8'h10, 32'hA5);
    bw(8'h00, 32'h1);
    repeat (200) @(negedge clk);
    br(8'h1C, d); chk("R10", "tx stalled count", d, 32'd1);
    br(8'h08, d); chk("R10", "tx not done", d, 32'h2);
    bw(8'h10, 32'h3C);
    wait_done("R10");
    br(8'h24, d); chk("R9", "nothing received", d[23:16], 32'd0);

    // R13 stop keeps count
    bw(8'h00, 32'h0);
    bw(8'h18, 32'h7FF);
    bw(8'h1C, 32'd1);
    bw(8'h10, 32'h55);
    bw(8'h00, 32'h1);
    repeat (5000) @(negedge clk);
    bw(8'h00, 32'h0);
    repeat (3000) @(negedge clk);
    chk("R13", "sck idle after stop", {31'b0, sck}, 32'h0);
    br(8'h1C, d); chk("R13", "count kept", d, 32'd1);

    // R11 flush
    bw(8'h00, 32'h2);
    for (int k = 0; k < 3; k++) bw(8'h10, k);
    br(8'h24, d); chk("R11", "tx level before flush", d[15:8], 32'd3);
    bw(8'h00, 32'h2);
    br(8'h24, d); chk("R11", "tx empty after flush", d, 32'h0A);

    report();
  end
endmodule